// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns words written into a small internal queue into asynchronous serial frames on a single output line. Each frame is a start bit, then 8 or 9 data bits sent least significant bit first, then an optional parity bit, then one or two stop bits. Parity is available only when 8-bit words are selected. The polarity of the whole line can be flipped, and that includes the idle level. On request the block sends a break, which holds the line at the active level for twelve bit periods.

Bit timing comes from a 16-bit divisor combined with a prescaler of sixteen or four. When flow control is enabled, a clear-to-send input must be high for a new frame to start. The transmitter looks at that input only when it is about to start a frame, so a frame that has already begun always runs to completion. A one-cycle completion pulse marks the end of the last stop bit once the queue is empty.

The framing state machine has six states. ST_IDLE holds the line at idle. ST_START drives the start bit. ST_DATA shifts out the data bits. ST_PAR drives the parity bit. ST_STOP drives the stop bits. ST_BRK drives the break. The transitions are:
- ST_IDLE to ST_BRK when a break is pending.
- ST_IDLE to ST_START when the queue is not empty and flow control allows a frame.
- ST_START to ST_DATA after one bit period.
- ST_DATA to ST_PAR after the last data bit when parity is enabled; ST_DATA to ST_STOP otherwise.
- ST_PAR to ST_STOP after one bit period.
- ST_STOP to ST_IDLE after the last stop bit.
- ST_BRK to ST_IDLE after twelve bit periods.

Top module: `uart_tx_core`

## Requirements
- R1: After reset, tx_out sits at the idle level (1 when cfg_inv_idle=0, 0 when cfg_inv_idle=1), q_empty=1, q_full=0, q_overflow=0 and tx_done=0.
- R2: A frame (shown non-inverted) is a start bit at 0, then the data LSB first, then the stop bits at 1. The data is 8 bits when cfg_nine=0 and 9 bits when cfg_nine=1.
- R3: cfg_parity encodes the parity mode: 2'b00 none, 2'b01 even, 2'b10 odd, 2'b11 none. With cfg_nine=0, even parity or odd parity adds one bit after the data and before the stop bits. That bit makes the count of ones in data plus parity even or odd, as selected. With cfg_nine=1, no parity bit is sent whatever cfg_parity holds.
- R4: A frame ends with one stop bit when cfg_two_stop=0 and with two stop bits when cfg_two_stop=1.
- R5: With cfg_inv_idle=1, every level on tx_out is inverted: idle, start, data, parity, stop and break.
- R6: One bit period lasts P × (cfg_brg+1) clock cycles, where P=16 when cfg_fast=0 and P=4 when cfg_fast=1.
- R7: A one-cycle pulse on brk_req produces exactly 12 bit periods at the active level (0 non-inverted), after which the line returns to idle. A request made during a frame waits until that frame has finished.
- R8: With cfg_flow_en=1, a frame starts only while cts=1. Dropping cts after a frame has started does not shorten or corrupt that frame. With cfg_flow_en=0, cts is ignored.
- R9: The queue holds 4 words and sends them in write order. q_full is 1 while it holds 4 words.
- R10: A write while q_full=1 is dropped and sets q_overflow, which then stays at 1 until reset.
- R11: tx_done is a single-cycle pulse that occurs when the last stop bit ends and the queue is empty. The cycle after it, tx_out is at the idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the transmit queue |
| wr_data | input | 9 | Word to queue; bit 8 is used only in 9-bit mode |
| cfg_nine | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| cfg_parity | input | 2 | Parity mode: 00 none, 01 even, 10 odd, 11 none |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| cfg_inv_idle | input | 1 | 1 inverts every level on the line |
| cfg_fast | input | 1 | Prescaler: 1 selects divide-by-4, 0 selects divide-by-16 |
| cfg_brg | input | 16 | Bit divisor; the bit period is prescale × (cfg_brg+1) |
| cfg_flow_en | input | 1 | Enables clear-to-send gating of frame starts |
| cts | input | 1 | Clear to send, active high |
| brk_req | input | 1 | Pulse that requests a 12-bit break |
| tx_out | output | 1 | Serial line |
| q_empty | output | 1 | Transmit queue is empty |
| q_full | output | 1 | Transmit queue is full |
| q_overflow | output | 1 | Sticky flag for a dropped write |
| tx_done | output | 1 | Pulse at the end of the last frame |

## Verification
The hardest situations to reach from the ports depend on timing. One is cts falling in the very cycle after a frame has been taken. Another is a break request arriving while a frame is in flight. A third is a full queue meeting further writes while flow control is holding frames back. Directed sequences set these up deliberately. They keep cts low while six words are written, then raise cts for a single cycle, so exactly one frame starts and the bench can watch it finish while the other words wait. They also pulse brk_req a few bit periods into a frame, then check the frame's contents and the exact length of the break that follows. Randomised bursts of one to four words cover every combination of data width, parity mode, stop count, polarity and divisor. Bursts of several words put frames back to back, so a missing second stop bit shows up as a misread start bit.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_BRK
    } tx_state_t;

    localparam logic [1:0] PAR_NONE = 2'b00;
    localparam logic [1:0] PAR_EVEN = 2'b01;
    localparam logic [1:0] PAR_ODD  = 2'b10;

    localparam int BRK_BITS = 12;

endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
    parameter int W     = 9,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_req,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full,
    output logic         ovf
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          push, do_pop;

    assign full   = (cnt_q == CW'(DEPTH));
    assign empty  = (cnt_q == '0);
    assign push   = push_req && !full;
    assign do_pop = pop && !empty;
    assign dout   = mem[rp_q];

    always_ff @(posedge clk) begin
        if (push) mem[wp_q] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
            ovf   <= 1'b0;
        end else begin
            if (push)
                wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
            if (do_pop)
                rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
            unique case ({push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
            if (push_req && full) ovf <= 1'b1;
        end
    end

endmodule

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
    parameter int BRG_W    = 16,
    parameter int PRE_SLOW = 16,
    parameter int PRE_FAST = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             sel_fast,
    input  logic [BRG_W-1:0] brg,
    output logic             tick
);
    localparam int PCW = (PRE_SLOW > 1) ? $clog2(PRE_SLOW) : 1;

    logic [PCW-1:0]   pc_q, pc_lim;
    logic [BRG_W-1:0] bc_q;
    logic             pc_wrap;

    assign pc_lim  = sel_fast ? PCW'(PRE_FAST - 1) : PCW'(PRE_SLOW - 1);
    assign pc_wrap = (pc_q == pc_lim);
    assign tick    = run && pc_wrap && (bc_q == brg);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= '0;
            bc_q <= '0;
        end else if (!run) begin
            pc_q <= '0;
            bc_q <= '0;
        end else if (pc_wrap) begin
            pc_q <= '0;
            bc_q <= (bc_q == brg) ? '0 : bc_q + 1'b1;
        end else begin
            pc_q <= pc_q + 1'b1;
        end
    end

endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_rdata,
    input  logic              cts_ok,
    input  logic              brk_req,
    input  logic              cfg_nine,
    input  logic [1:0]        cfg_parity,
    input  logic              cfg_two_stop,
    output logic              pop,
    output logic              run,
    output logic              line_o,
    output logic              done
);
    localparam int BCW = $clog2(BRK_BITS + 1);

    tx_state_t         state_q, state_d;
    logic [DATA_W-1:0] shift_q;
    logic [BCW-1:0]    cnt_q;
    logic              stop_q, par_q, par_en_q, nine_q, two_q, brk_pend_q;
    logic              last_data, last_stop, last_brk, start_frame, start_brk;

    assign last_data   = (cnt_q == (nine_q ? BCW'(DATA_W - 1) : BCW'(DATA_W - 2)));
    assign last_stop   = (stop_q == two_q);
    assign last_brk    = (cnt_q == BCW'(BRK_BITS - 1));
    assign start_brk   = (state_q == ST_IDLE) && brk_pend_q;
    assign start_frame = (state_q == ST_IDLE) && !brk_pend_q && !fifo_empty && cts_ok;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_brk)        state_d = ST_BRK;
                else if (start_frame) state_d = ST_START;
            end
            ST_START: if (tick) state_d = ST_DATA;
            ST_DATA:  if (tick && last_data) state_d = par_en_q ? ST_PAR : ST_STOP;
            ST_PAR:   if (tick) state_d = ST_STOP;
            ST_STOP:  if (tick && last_stop) state_d = ST_IDLE;
            ST_BRK:   if (tick && last_brk) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q    <= '0;
            cnt_q      <= '0;
            stop_q     <= 1'b0;
            par_q      <= 1'b0;
            par_en_q   <= 1'b0;
            nine_q     <= 1'b0;
            two_q      <= 1'b0;
            brk_pend_q <= 1'b0;
        end else begin
            brk_pend_q <= (brk_pend_q && !start_brk) || brk_req;
            if (start_frame) begin
                shift_q  <= fifo_rdata;
                nine_q   <= cfg_nine;
                two_q    <= cfg_two_stop;
                par_en_q <= !cfg_nine && (cfg_parity == PAR_EVEN || cfg_parity == PAR_ODD);
                par_q    <= (^fifo_rdata[DATA_W-2:0]) ^ (cfg_parity == PAR_ODD);
                cnt_q    <= '0;
                stop_q   <= 1'b0;
            end else if (start_brk) begin
                cnt_q <= '0;
            end else if (tick) begin
                if (state_q == ST_DATA) begin
                    shift_q <= shift_q >> 1;
                    cnt_q   <= cnt_q + 1'b1;
                end
                if (state_q == ST_BRK)  cnt_q  <= cnt_q + 1'b1;
                if (state_q == ST_STOP) stop_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        pop  = start_frame;
        run  = (state_q != ST_IDLE);
        done = (state_q == ST_STOP) && tick && last_stop && fifo_empty;
        unique case (state_q)
            ST_IDLE:  line_o = 1'b1;
            ST_START: line_o = 1'b0;
            ST_DATA:  line_o = shift_q[0];
            ST_PAR:   line_o = par_q;
            ST_STOP:  line_o = 1'b1;
            ST_BRK:   line_o = 1'b0;
            default:  line_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core #(
    parameter int DATA_W     = 9,
    parameter int FIFO_DEPTH = 4,
    parameter int BRG_W      = 16,
    parameter int PRE_SLOW   = 16,
    parameter int PRE_FAST   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cfg_nine,
    input  logic [1:0]        cfg_parity,
    input  logic              cfg_two_stop,
    input  logic              cfg_inv_idle,
    input  logic              cfg_fast,
    input  logic [BRG_W-1:0]  cfg_brg,
    input  logic              cfg_flow_en,
    input  logic              cts,
    input  logic              brk_req,
    output logic              tx_out,
    output logic              q_empty,
    output logic              q_full,
    output logic              q_overflow,
    output logic              tx_done
);
    logic [DATA_W-1:0] fifo_rdata;
    logic              fifo_pop, bit_tick, baud_run, line_raw, cts_ok;

    assign cts_ok = !cfg_flow_en || cts;
    assign tx_out = line_raw ^ cfg_inv_idle;

    uart_tx_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (wr_en),
        .pop      (fifo_pop),
        .din      (wr_data),
        .dout     (fifo_rdata),
        .empty    (q_empty),
        .full     (q_full),
        .ovf      (q_overflow)
    );

    uart_tx_baud #(.BRG_W(BRG_W), .PRE_SLOW(PRE_SLOW), .PRE_FAST(PRE_FAST)) u_baud (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (baud_run),
        .sel_fast (cfg_fast),
        .brg      (cfg_brg),
        .tick     (bit_tick)
    );

    uart_tx_framer #(.DATA_W(DATA_W)) u_frm (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (bit_tick),
        .fifo_empty   (q_empty),
        .fifo_rdata   (fifo_rdata),
        .cts_ok       (cts_ok),
        .brk_req      (brk_req),
        .cfg_nine     (cfg_nine),
        .cfg_parity   (cfg_parity),
        .cfg_two_stop (cfg_two_stop),
        .pop          (fifo_pop),
        .run          (baud_run),
        .line_o       (line_raw),
        .done         (tx_done)
    );

endmodule

// File: rtl/uart_tx_checker.sv
module uart_tx_checker #(
    parameter int BRG_W    = 16,
    parameter int PRE_SLOW = 16,
    parameter int PRE_FAST = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             q_full,
    input logic             q_empty,
    input logic             q_overflow,
    input logic             tx_done,
    input logic             tx_out,
    input logic             cfg_inv_idle,
    input logic             cfg_flow_en,
    input logic             cfg_fast,
    input logic [BRG_W-1:0] cfg_brg,
    input logic             cts,
    input logic             pop,
    input logic             tick,
    input logic             run
);
    logic [31:0] per_cnt;
    logic [31:0] period;

    assign period = (cfg_fast ? 32'(PRE_FAST) : 32'(PRE_SLOW)) * (32'(cfg_brg) + 32'd1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            per_cnt <= '0;
        else if (!run || tick) per_cnt <= '0;
        else                   per_cnt <= per_cnt + 32'd1;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) wr_en && q_full |=> q_overflow); // R10
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) q_overflow |=> q_overflow); // R10
    AST_FULL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) !(q_full && q_empty)); // R9
    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) q_full && !pop |=> q_full); // R9
    AST_BIT_PERIOD: assert property (@(posedge clk) disable iff (!rst_n) tick |-> per_cnt == period - 32'd1); // R6
    AST_CTS_GATE: assert property (@(posedge clk) disable iff (!rst_n) pop |-> (!cfg_flow_en || cts)); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) tx_done |=> !tx_done); // R11
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) tx_done |=> tx_out == !cfg_inv_idle); // R11

endmodule

bind uart_tx_core uart_tx_checker #(.BRG_W(BRG_W), .PRE_SLOW(PRE_SLOW), .PRE_FAST(PRE_FAST)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .q_full       (q_full),
    .q_empty      (q_empty),
    .q_overflow   (q_overflow),
    .tx_done      (tx_done),
    .tx_out       (tx_out),
    .cfg_inv_idle (cfg_inv_idle),
    .cfg_flow_en  (cfg_flow_en),
    .cfg_fast     (cfg_fast),
    .cfg_brg      (cfg_brg),
    .cts          (cts),
    .pop          (fifo_pop),
    .tick         (bit_tick),
    .run          (baud_run)
);

// File: tb/test_uart_tx_core.sv
module test_uart_tx_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [8:0]  wr_data = '0;
    logic        cfg_nine = 1'b0;
    logic [1:0]  cfg_parity = 2'b00;
    logic        cfg_two_stop = 1'b0;
    logic        cfg_inv_idle = 1'b0;
    logic        cfg_fast = 1'b1;
    logic [15:0] cfg_brg = 16'd0;
    logic        cfg_flow_en = 1'b0;
    logic        cts = 1'b0;
    logic        brk_req = 1'b0;
    logic        tx_out, q_empty, q_full, q_overflow, tx_done;

    int n_chk = 0;
    int n_bad = 0;
    int done_cnt = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    uart_tx_core i_uart_tx_core (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .cfg_nine(cfg_nine), .cfg_parity(cfg_parity), .cfg_two_stop(cfg_two_stop),
        .cfg_inv_idle(cfg_inv_idle), .cfg_fast(cfg_fast), .cfg_brg(cfg_brg),
        .cfg_flow_en(cfg_flow_en), .cts(cts), .brk_req(brk_req),
        .tx_out(tx_out), .q_empty(q_empty), .q_full(q_full),
        .q_overflow(q_overflow), .tx_done(tx_done)
    );

    always @(posedge clk) begin
        if (rst_n && tx_done) done_cnt <= done_cnt + 1;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 190000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual=%0d expected<%0d cycles", cyc, 190000);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    function automatic int bit_period();
        return (cfg_fast ? 4 : 16) * (int'(cfg_brg) + 1);
    endfunction

    function automatic logic idle_lvl();
        return !cfg_inv_idle;
    endfunction

    function automatic logic exp_parity(input logic [8:0] w, input logic [1:0] pm);
        return (^w[7:0]) ^ (pm == 2'b10);
    endfunction

    function automatic logic par_on();
        return !cfg_nine && (cfg_parity == 2'b01 || cfg_parity == 2'b10);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Receives one frame and compares it with w (called at a negedge).
    task automatic rx_frame(input logic [8:0] w, input string req);
        int         p;
        int         nb;
        int         errs;
        logic [8:0] got;
        logic [8:0] expw;
        p    = bit_period();
        nb   = cfg_nine ? 9 : 8;
        errs = 0;
        got  = '0;
        expw = cfg_nine ? w : {1'b0, w[7:0]};
        while (tx_out == idle_lvl()) @(negedge clk);
        repeat (p / 2) @(negedge clk);
        if (tx_out != !idle_lvl()) errs++;
        for (int k = 0; k < nb; k++) begin
            repeat (p) @(negedge clk);
            got[k] = tx_out ^ cfg_inv_idle;
        end
        if (par_on()) begin
            repeat (p) @(negedge clk);
            if ((tx_out ^ cfg_inv_idle) != exp_parity(w, cfg_parity)) errs++;
        end
        for (int s = 0; s < (cfg_two_stop ? 2 : 1); s++) begin
            repeat (p) @(negedge clk);
            if (tx_out != idle_lvl()) errs++;
        end
        chk(errs == 0 && got == expw, req, "frame data/framing", {errs, got}, {32'd0, expw});
    endtask

    task automatic meas_active(output int len);
        while (tx_out == idle_lvl()) @(negedge clk);
        len = 0;
        while (tx_out != idle_lvl()) begin
            len++;
            @(negedge clk);
        end
    endtask

    task automatic do_reset(input logic inv);
        @(negedge clk);
        cfg_inv_idle = inv;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_out == !inv, "R1", "idle level after reset", tx_out, !inv);
        chk(q_empty && !q_full && !q_overflow && !tx_done, "R1", "flags after reset",
            {q_empty, q_full, q_overflow, tx_done}, 4'b1000);
    endtask

    task automatic push_word(input logic [8:0] w);
        wr_en = 1'b1;
        wr_data = w;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        logic [8:0] words [4];
        int         len;
        int         d0;
        int         k;
        void'($urandom(32'd20240611));

        // R1 and R5: reset state in both polarities
        do_reset(1'b1);
        do_reset(1'b0);

        // R6: start bit length (bit 0 of the word is 1, so the active run is the start bit only)
        cfg_fast = 1'b0; cfg_brg = 16'd2;
        push_word(9'h0FF);
        meas_active(len);
        chk(len == 48, "R6", "start bit length div16 brg2", len, 48);
        repeat (12 * 48) @(negedge clk);
        cfg_fast = 1'b1; cfg_brg = 16'd5;
        push_word(9'h001);
        meas_active(len);
        chk(len == 24, "R6", "start bit length div4 brg5", len, 24);
        repeat (12 * 24) @(negedge clk);

        // R7: break from idle, length 12 bit periods
        brk_req = 1'b1; @(negedge clk); brk_req = 1'b0;
        meas_active(len);
        chk(len == 12 * 24, "R7", "break length", len, 12 * 24);

        // R7 and R5: break requested mid-frame, inverted line, waits for frame end
        cfg_inv_idle = 1'b1; cfg_fast = 1'b0; cfg_brg = 16'd0;
        repeat (4) @(negedge clk);
        push_word(9'h0A5);
        fork
            begin
                rx_frame(9'h0A5, "R7");
                meas_active(len);
                chk(len == 12 * 16, "R7", "deferred break length", len, 12 * 16);
            end
            begin
                repeat (3 * 16) @(negedge clk);
                brk_req = 1'b1; @(negedge clk); brk_req = 1'b0;
            end
        join
        chk(tx_out == 1'b0, "R5", "inverted idle after break", tx_out, 0);

        // R8, R9, R10: flow control holds frames, queue fills, extra writes are dropped
        do_reset(1'b0);
        cfg_fast = 1'b1; cfg_brg = 16'd1; cfg_nine = 1'b0; cfg_parity = 2'b01;
        cfg_two_stop = 1'b0; cfg_flow_en = 1'b1; cts = 1'b0;
        for (int i = 0; i < 4; i++) words[i] = 9'($urandom_range(0, 255));
        for (int i = 0; i < 4; i++) push_word(words[i]);
        chk(q_full == 1'b1 && q_overflow == 1'b0, "R9", "full after four writes",
            {q_full, q_overflow}, 2'b10);
        push_word(9'h1FF);
        push_word(9'h155);
        chk(q_overflow == 1'b1, "R10", "overflow set on write when full", q_overflow, 1);
        len = 0;
        repeat (100) begin
            @(negedge clk);
            if (tx_out != idle_lvl()) len++;
        end
        chk(len == 0, "R8", "no frame while cts low", len, 0);
        cts = 1'b1;
        @(negedge clk);
        cts = 1'b0;
        rx_frame(words[0], "R8");
        len = 0;
        repeat (5 * bit_period()) begin
            @(negedge clk);
            if (tx_out != idle_lvl()) len++;
        end
        chk(len == 0 && q_empty == 1'b0, "R8", "next frame held after cts drop",
            {len, q_empty}, 0);
        cts = 1'b1;
        for (int i = 1; i < 4; i++) rx_frame(words[i], "R9");
        repeat (bit_period() + 2) @(negedge clk);
        chk(q_overflow == 1'b1 && q_empty == 1'b1, "R10", "overflow sticky after drain",
            {q_overflow, q_empty}, 2'b11);

        // R8: with flow control off, cts is ignored
        cfg_flow_en = 1'b0; cts = 1'b0;
        push_word(9'h03C);
        rx_frame(9'h03C, "R8");
        repeat (bit_period() + 2) @(negedge clk);

        // R2, R3, R4, R5, R6, R11: random bursts
        for (int b = 0; b < 28; b++) begin
            cfg_nine     = 1'($urandom_range(0, 1));
            cfg_parity   = 2'($urandom_range(0, 3));
            cfg_two_stop = 1'($urandom_range(0, 1));
            cfg_inv_idle = 1'($urandom_range(0, 1));
            cfg_fast     = 1'($urandom_range(0, 1));
            cfg_brg      = 16'($urandom_range(0, 3));
            if (b == 0) begin cfg_nine = 1'b1; cfg_parity = 2'b01; end
            if (b == 1) begin cfg_nine = 1'b0; cfg_parity = 2'b10; cfg_two_stop = 1'b1; end
            k = $urandom_range(1, 4);
            for (int i = 0; i < 4; i++) words[i] = 9'($urandom_range(0, 511));
            repeat (3) @(negedge clk);
            d0 = done_cnt;
            fork
                begin
                    for (int i = 0; i < k; i++) begin
                        wr_en = 1'b1; wr_data = words[i];
                        @(negedge clk);
                    end
                    wr_en = 1'b0;
                end
                begin
                    for (int i = 0; i < k; i++) begin
                        if (par_on())          rx_frame(words[i], "R3");
                        else if (cfg_two_stop) rx_frame(words[i], "R4");
                        else                   rx_frame(words[i], "R2");
                    end
                end
            join
            repeat (bit_period() + 2) @(negedge clk);
            chk(done_cnt == d0 + 1, "R11", "one done pulse per burst", done_cnt - d0, 1);
            chk(tx_out == idle_lvl(), "R5", "idle level after burst", tx_out, idle_lvl());
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule